// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic. Each offset is split across two 9-bit registers, a low part and a high part, so four registers in all. The offsets reset to fixed defaults. Software-side logic can overwrite them through the FIFO's own data input while the active-low load strobe is held LOW.

Writes are taken on the write clock. They go to the register chosen by a rotating write pointer. The pointer keeps its place while loading is paused, so a partial update picks up at the next register later. A second rotating pointer, clocked by the read clock, returns the register contents on a data output. The two offsets are presented as full-width values to the flag comparators.

The offset width is `$clog2(DEPTH)` bits. The low register supplies the bottom 9 bits and the high register supplies the remaining ones. High-register bits above that width are neither stored nor returned.

Top module: `flag_ofs_loader`

## Requirements
- R1: After reset, both offsets equal 7, `data_o` is 0, and both pointers select the empty-offset low register.
- R2: On a rising `wclk_i` edge with `load_ni` and `wen_ni` both LOW, `data_i` is stored in the register selected by the write pointer. The selector codes are 0 for empty low, 1 for empty high, 2 for full low and 3 for full high.
- R3: Each write advances the write pointer one step in the order 0, 1, 2, 3. The fifth write in a row lands in register 0 again.
- R4: While no write occurs, the write pointer holds its position. The next write after a pause goes to the register after the last one written.
- R5: A write-clock edge with `load_ni` HIGH or `wen_ni` HIGH changes no register, whatever `data_i` holds.
- R6: On a rising `rclk_i` edge with `load_ni`, `ren1_ni` and `ren2_ni` all LOW, `data_o` takes the register selected by the read pointer, and the read pointer then advances in the same circular order. In every other case `data_o` holds its value.
- R7: A read needs both read enables LOW and `load_ni` LOW. If any one of them is HIGH, neither `data_o` nor the read pointer changes.
- R8: A high register stores only `data_i[$clog2(DEPTH)-10:0]`. Its other bits read back as zero on `data_o`. With the default DEPTH of 16384 that is 5 stored bits.
- R9: `empty_ofs_o` is the empty high register placed above the 9-bit empty low register. `full_ofs_o` is formed the same way from the full registers.
- R10: The read pointer and the write pointer move independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Offset access strobe, active low |
| wen_ni | input | 1 | Write enable, active low |
| ren1_ni | input | 1 | First read enable, active low |
| ren2_ni | input | 1 | Second read enable, active low |
| data_i | input | 9 | Write data |
| data_o | output | 9 | Read-back data |
| empty_ofs_o | output | $clog2(DEPTH) | Almost-empty offset |
| full_ofs_o | output | $clog2(DEPTH) | Almost-full offset |

## Verification
Some properties are checked on every clock edge. These are the pointer stepping and holding, that a write to the empty low register lands, that offsets and `data_o` stay stable when nothing is enabled, and that unused high bits read as zero. The per-cycle checks cannot show that a value written several steps earlier comes back in the right slot and order. They also cannot show that a paused sequence resumes at the correct register, or that the two pointers drift apart correctly. Those are covered only by the bench scenarios, which compare against a behavioural model.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  localparam int unsigned REG_W    = 9;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [SEL_W-1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/flag_ofs_ptr.sv
module flag_ofs_ptr
  import flag_ofs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_nxt;

  // natural wrap of the selector gives the circular order
  assign sel_nxt = sel_o + SEL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_o <= SEL_EMPTY_LO;
    else if (adv_i) sel_o <= sel_nxt;
  end
endmodule

// File: rtl/flag_ofs_bank.sv
module flag_ofs_bank
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH   = 16384,
  parameter logic [8:0]  LO_DEF  = 9'h007,
  parameter logic [8:0]  HI_DEF  = 9'h000,
  localparam int unsigned OFS_W  = $clog2(DEPTH),
  localparam int unsigned HI_W   = OFS_W - REG_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [SEL_W-1:0]                  wsel_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [NUM_REGS-1:0][REG_W-1:0]    bank_o,
  output logic [OFS_W-1:0]                  empty_ofs_o,
  output logic [OFS_W-1:0]                  full_ofs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (wsel_i == SEL_W'(g));
    if ((g % 2) == 0) begin : g_lo
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= LO_DEF;
        else if (hit) q <= wdata_i;
      end
      assign bank_o[g] = q;
    end else begin : g_hi
      // only the bits the depth needs are kept
      logic [HI_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= HI_DEF[HI_W-1:0];
        else if (hit) q <= wdata_i[HI_W-1:0];
      end
      assign bank_o[g] = {{(REG_W-HI_W){1'b0}}, q};
    end
  end

  assign empty_ofs_o = {bank_o[SEL_EMPTY_HI][HI_W-1:0], bank_o[SEL_EMPTY_LO]};
  assign full_ofs_o  = {bank_o[SEL_FULL_HI][HI_W-1:0],  bank_o[SEL_FULL_LO]};
endmodule

// File: rtl/flag_ofs_readback.sv
module flag_ofs_readback
  import flag_ofs_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           re_i,
  input  logic [SEL_W-1:0]               rsel_i,
  input  logic [NUM_REGS-1:0][REG_W-1:0] bank_i,
  output logic [REG_W-1:0]               data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (re_i) data_o <= bank_i[rsel_i];
  end
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH  = 16384,
  parameter logic [8:0]  LO_DEF = 9'h007,
  parameter logic [8:0]  HI_DEF = 9'h000,
  localparam int unsigned OFS_W = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             wen_ni,
  input  logic             ren1_ni,
  input  logic             ren2_ni,
  input  logic [8:0]       data_i,
  output logic [8:0]       data_o,
  output logic [OFS_W-1:0] empty_ofs_o,
  output logic [OFS_W-1:0] full_ofs_o
);
  logic                           wr_en, rd_en;
  logic [SEL_W-1:0]               wr_sel, rd_sel;
  logic [NUM_REGS-1:0][REG_W-1:0] bank;

  assign wr_en = !load_ni && !wen_ni;
  assign rd_en = !load_ni && !ren1_ni && !ren2_ni;

  flag_ofs_ptr u_wptr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .adv_i (wr_en),
    .sel_o (wr_sel)
  );

  flag_ofs_ptr u_rptr (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .adv_i (rd_en),
    .sel_o (rd_sel)
  );

  flag_ofs_bank #(
    .DEPTH (DEPTH),
    .LO_DEF(LO_DEF),
    .HI_DEF(HI_DEF)
  ) u_bank (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en),
    .wsel_i     (wr_sel),
    .wdata_i    (data_i),
    .bank_o     (bank),
    .empty_ofs_o(empty_ofs_o),
    .full_ofs_o (full_ofs_o)
  );

  flag_ofs_readback u_rdbk (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .re_i  (rd_en),
    .rsel_i(rd_sel),
    .bank_i(bank),
    .data_o(data_o)
  );
endmodule

// File: rtl/flag_ofs_loader_chk.sv
module flag_ofs_loader_chk
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH  = 16384,
  localparam int unsigned OFS_W = $clog2(DEPTH),
  localparam int unsigned HI_W  = OFS_W - REG_W
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic             wen_ni,
  input logic             ren1_ni,
  input logic             ren2_ni,
  input logic [8:0]       data_i,
  input logic [8:0]       data_o,
  input logic [OFS_W-1:0] empty_ofs_o,
  input logic [OFS_W-1:0] full_ofs_o,
  input logic [SEL_W-1:0] wr_sel,
  input logic [SEL_W-1:0] rd_sel
);
  logic wr_go, rd_go;
  assign wr_go = !load_ni && !wen_ni;
  assign rd_go = !load_ni && !ren1_ni && !ren2_ni;

  a_r2_write_lands: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_go && wr_sel == SEL_EMPTY_LO) |=> empty_ofs_o[REG_W-1:0] == $past(data_i));

  a_r3_wptr_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_go |=> wr_sel == SEL_W'($past(wr_sel) + SEL_W'(1)));

  a_r4_wptr_hold: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_go |=> $stable(wr_sel));

  a_r5_no_write: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_go |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  a_r6_data_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(data_o));

  a_r7_rptr_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(rd_sel));

  a_r8_hi_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_go && rd_sel[0]) |=> data_o[REG_W-1:HI_W] == '0);
endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .wen_ni     (wen_ni),
  .ren1_ni    (ren1_ni),
  .ren2_ni    (ren2_ni),
  .data_i     (data_i),
  .data_o     (data_o),
  .empty_ofs_o(empty_ofs_o),
  .full_ofs_o (full_ofs_o),
  .wr_sel     (wr_sel),
  .rd_sel     (rd_sel)
);

// File: tb/flag_ofs_loader_tb_top.sv
module flag_ofs_loader_tb_top;
  localparam int DEPTH = 16384;
  localparam int OFS_W = $clog2(DEPTH);
  localparam int HI_W  = OFS_W - 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_ni = 1'b1, wen_ni = 1'b1, ren1_ni = 1'b1, ren2_ni = 1'b1;
  logic [8:0] data_i = '0;
  logic [8:0] data_o;
  logic [OFS_W-1:0] empty_ofs_o, full_ofs_o;

  always #5 clk = ~clk;

  flag_ofs_loader #(.DEPTH(DEPTH)) dut_i (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni),
    .load_ni(load_ni), .wen_ni(wen_ni), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
    .data_i(data_i), .data_o(data_o),
    .empty_ofs_o(empty_ofs_o), .full_ofs_o(full_ofs_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int regs[4];
  int wp, rp, exp_do;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "empty_ofs_o", int'(empty_ofs_o), regs[1] * 512 + regs[0]);
    check(req, "full_ofs_o",  int'(full_ofs_o),  regs[3] * 512 + regs[2]);
    check(req, "data_o",      int'(data_o),      exp_do);
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic ld, input logic we, input logic r1, input logic r2,
                      input int d, input string req);
    load_ni = ld; wen_ni = we; ren1_ni = r1; ren2_ni = r2; data_i = 9'(d);
    @(posedge clk);
    if (!ld && !r1 && !r2) begin
      exp_do = regs[rp];
      rp = (rp + 1) % 4;
    end
    if (!ld && !we) begin
      regs[wp] = (wp % 2 == 1) ? (d & ((1 << HI_W) - 1)) : (d & 9'h1FF);
      wp = (wp + 1) % 4;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    regs = '{7, 0, 7, 0};
    wp = 0; rp = 0; exp_do = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");
    step(1, 1, 1, 1, 9'h1FF, "R1");

    // full pass, high registers get bits above the stored width
    step(0, 0, 1, 1, 9'h0A5, "R2");
    step(0, 0, 1, 1, 9'h1F3, "R8");
    step(0, 0, 1, 1, 9'h055, "R2");
    step(0, 0, 1, 1, 9'h0FF, "R8");
    check("R9", "empty_ofs_o", int'(empty_ofs_o), 32'h13 * 512 + 32'h0A5);
    // fifth write wraps to empty low
    step(0, 0, 1, 1, 9'h123, "R3");

    // stimulus that must not write
    step(1, 0, 1, 1, 9'h1FF, "R5");
    step(0, 1, 1, 1, 9'h1FF, "R5");
    step(1, 1, 1, 1, 9'h000, "R4");
    // resume at empty high
    step(0, 0, 1, 1, 9'h0AA, "R4");
    step(1, 1, 1, 1, 9'h000, "R4");
    step(0, 0, 1, 1, 9'h1C3, "R4");

    // read-back walk with wrap
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 9'h000, "R6");
    step(0, 1, 1, 1, 9'h000, "R6");
    // blocked reads
    step(0, 1, 1, 0, 9'h000, "R7");
    step(0, 1, 0, 1, 9'h000, "R7");
    step(1, 1, 0, 0, 9'h000, "R7");
    step(0, 1, 0, 0, 9'h000, "R7");

    // pointers drift apart
    step(0, 0, 1, 1, 9'h1E1, "R10");
    step(0, 1, 0, 0, 9'h000, "R10");
    step(0, 0, 1, 1, 9'h0F0, "R10");
    step(0, 1, 0, 0, 9'h000, "R10");
    step(0, 1, 0, 0, 9'h000, "R10");

    // mixed pattern of writes, pauses and reads
    for (int i = 0; i < 24; i++) begin
      case (i % 4)
        0: step(0, 0, 1, 1, (i * 37 + 11) % 512, "R9");
        1: step(0, 1, 0, 0, 0, "R6");
        2: step(1, 1, 1, 1, 9'h1FF, "R5");
        default: step(0, 0, 1, 1, (i * 91 + 300) % 512, "R8");
      endcase
    end

    done = 1;
    summary();
    $finish;
  end
endmodule